// File: doc/BRIEF.md
# Inband Loopback Code Detector

The detector watches a received serial line for two repeating loopback codes, one that asks the far end to close a loop and one that asks it to open the loop. Each code has its own 8-bit pattern register and a 2-bit length select. For each code the block sets a status level once the code has been present without interruption for a persistence time. That time depends on the line mode: about 30 ms on E1 lines and about 40 ms on T1/J1 lines.

Matching works on windows of `WIN` received bits. Within a window, each received bit is compared with the bit received one code period earlier, and the mismatches are counted. The window also records whether any aligned group of L bits equals some rotation of the programmed pattern. A window passes if it has at most `MISS_MAX` periodicity mismatches and at least one such rotation hit. Because of this tolerance, scattered bit errors do not break detection, and neither do framing bits that interrupt a framed code. The persistence time is counted in bit-enable ticks and is credited only when a window passes.

Each code has its own small state machine with three states:
- **OFF**: the detector is disabled. It moves to HUNT when enabled.
- **HUNT**: it builds up persistence. A passing window adds `WIN` ticks. A failing window clears the count. When the count exceeds the mode limit, it moves to FOUND.
- **FOUND**: the status is high. A failing window sends it back to HUNT with the count cleared.

Two events override every state. Disabling the detector always forces OFF. Changing a code's pattern or length forces that code to HUNT with a cleared count.

Top module: `ilb_detector`

## Requirements
- R1: After reset both status outputs are low.
- R2: Length select 0,1,2,3 means a code length L of 5,6,7,8 bits. The code occupies pattern bits [L-1:0], and bit L-1 is sent first. Any starting phase of the code on the line is accepted.
- R3: A stream carrying only the activate code leaves the deactivate status low.
- R4: A window passes only if some aligned L-bit group equals a rotation of the pattern. A stream that is periodic with length L but carries another pattern never sets the status.
- R5: With `e1_mode`=1, the status rises at the end of the first passing window that brings the passing ticks accumulated since the last failure or restart above `E1_TICKS`.
- R6: With `e1_mode`=0, the same rule applies with limit `T1_TICKS`. A code held for longer than `E1_TICKS` but not longer than `T1_TICKS` leaves the status low.
- R7: A code with one flipped bit in every 97 is still detected.
- R8: A code interrupted by one inserted framing bit every 193 bits is still detected.
- R9: A failing window clears the status in the cycle after the window result, and it also clears the accumulated persistence.
- R10: Changing a code's pattern or length drops that code's status in the next cycle and discards its history.
- R11: While `det_en` is low, both statuses are low and nothing accumulates.
- R12: Only cycles with `bit_en` high carry line bits. Idle cycles neither shift history nor advance windows.
- R13: A 3-bit or 4-bit code programmed as its 6-bit or 8-bit repetition is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_en | input | 1 | Detector enable |
| bit_en | input | 1 | Marks a cycle that carries a line bit |
| rx_bit | input | 1 | Received line bit |
| e1_mode | input | 1 | 1 = E1 persistence limit, 0 = T1/J1 limit |
| act_pat | input | 8 | Activate code pattern |
| act_len | input | 2 | Activate code length select |
| deact_pat | input | 8 | Deactivate code pattern |
| deact_len | input | 2 | Deactivate code length select |
| act_found | output | 1 | Activate code detected |
| deact_found | output | 1 | Deactivate code detected |

## Verification
The bench targets these failure modes:
- **Persistence boundary.** A T1 stream is held just past the E1 limit but short of the T1 limit. A detector that used the wrong limit, or compared with "at least" instead of "more than", would raise the status too early.
- **Right period, wrong pattern.** The bench sends a stream with the correct period but the wrong pattern. A matcher that checked only periodicity would accept it.
- **Errors and framing.** Injected bit errors and inserted framing bits would break a matcher that demanded perfect windows.
- **Clear and restart.** The bench removes the code, rewrites a pattern mid-detection and drops the enable. A design that kept stale history or stale persistence would hold the status high or raise it again too soon.
- **Idle cycles.** Idle cycles between bits catch a matcher that advanced on every clock instead of on line bits.

// File: rtl/ilb_pkg.sv
package ilb_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HUNT  = 2'd1,
        ST_FOUND = 2'd2
    } ilb_state_e;

    // Length select to code length in bits (5..8).
    function automatic logic [3:0] code_len(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    // True when the low len bits of grp equal any rotation of the low len bits of pat.
    function automatic logic rot_hit(input logic [7:0] grp, input logic [7:0] pat,
                                     input logic [3:0] len);
        logic [7:0]  mask;
        logic [15:0] dbl;
        logic        hit;
        mask = 8'hFF >> (4'd8 - len);
        dbl  = ({8'h00, pat & mask} << len) | {8'h00, pat & mask};
        hit  = 1'b0;
        for (int r = 0; r < 8; r++) begin
            if (r < int'(len)) begin
                if (((dbl >> r) & {8'h00, mask}) == {8'h00, grp & mask}) hit = 1'b1;
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/ilb_matcher.sv
module ilb_matcher
    import ilb_pkg::*;
#(
    parameter int WIN      = 256,
    parameter int MISS_MAX = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  logic [7:0] pat,
    input  logic [1:0] len_sel,
    output logic       restart,
    output logic       win_done,
    output logic       win_pass
);
    localparam int WIN_W  = (WIN > 2) ? $clog2(WIN) : 1;
    localparam int MISS_W = $clog2(WIN + 1);

    logic [7:0]        hist;
    logic [3:0]        fill;
    logic [WIN_W-1:0]  bcnt;
    logic [MISS_W-1:0] miss;
    logic              seen;
    logic [7:0]        pat_q;
    logic [1:0]        len_q;

    logic [3:0]        clen;
    logic              mism;
    logic [7:0]        hist_n;
    logic              hit_now;
    logic [MISS_W-1:0] miss_n;
    logic              last;

    always_comb begin
        clen    = code_len(len_q);
        mism    = (fill >= clen) && (rx_bit != hist[3'(clen - 4'd1)]);
        hist_n  = {hist[6:0], rx_bit};
        hit_now = ((fill + 4'd1) >= clen) && rot_hit(hist_n, pat_q, clen);
        miss_n  = miss + MISS_W'(mism);
        last    = (bcnt == WIN_W'(WIN - 1));
        restart = !en || (pat != pat_q) || (len_sel != len_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist     <= '0;
            fill     <= '0;
            bcnt     <= '0;
            miss     <= '0;
            seen     <= 1'b0;
            pat_q    <= '0;
            len_q    <= '0;
            win_done <= 1'b0;
            win_pass <= 1'b0;
        end else if (restart) begin
            fill     <= '0;
            bcnt     <= '0;
            miss     <= '0;
            seen     <= 1'b0;
            pat_q    <= pat;
            len_q    <= len_sel;
            win_done <= 1'b0;
            win_pass <= 1'b0;
        end else begin
            win_done <= 1'b0;
            win_pass <= 1'b0;
            if (bit_en) begin
                hist <= hist_n;
                if (fill != 4'd8) fill <= fill + 4'd1;
                if (last) begin
                    win_done <= 1'b1;
                    win_pass <= (miss_n <= MISS_W'(MISS_MAX)) && (seen || hit_now);
                    bcnt     <= '0;
                    miss     <= '0;
                    seen     <= 1'b0;
                end else begin
                    bcnt <= bcnt + WIN_W'(1);
                    miss <= miss_n;
                    seen <= seen || hit_now;
                end
            end
        end
    end

    // R12
    done_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(bit_en));

    // R10
    restart_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !win_done);

endmodule

// File: rtl/ilb_persist.sv
module ilb_persist
    import ilb_pkg::*;
#(
    parameter int WIN      = 256,
    parameter int E1_TICKS = 61440,
    parameter int T1_TICKS = 61760
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic e1_mode,
    input  logic restart,
    input  logic win_done,
    input  logic win_pass,
    output logic status
);
    localparam int MAXT   = (E1_TICKS > T1_TICKS) ? E1_TICKS : T1_TICKS;
    localparam int PERS_W = $clog2(MAXT + WIN + 1);

    ilb_state_e        state, state_n;
    logic [PERS_W-1:0] cnt, cnt_n, sum, limit;

    always_comb begin
        sum     = cnt + PERS_W'(WIN);
        limit   = e1_mode ? PERS_W'(E1_TICKS) : PERS_W'(T1_TICKS);
        state_n = state;
        cnt_n   = cnt;
        if (!en) begin
            state_n = ST_OFF;
            cnt_n   = '0;
        end else if (restart) begin
            state_n = ST_HUNT;
            cnt_n   = '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    state_n = ST_HUNT;
                    cnt_n   = '0;
                end
                ST_HUNT: begin
                    if (win_done) begin
                        if (!win_pass) begin
                            cnt_n = '0;
                        end else if (sum > limit) begin
                            state_n = ST_FOUND;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = sum;
                        end
                    end
                end
                ST_FOUND: begin
                    if (win_done && !win_pass) begin
                        state_n = ST_HUNT;
                        cnt_n   = '0;
                    end
                end
                default: begin
                    state_n = ST_OFF;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb status = (state == ST_FOUND);

    // R5
    rise_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(win_done && win_pass));

    // R9
    fail_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && !win_pass) |=> !status);

    // R11
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !status);

endmodule

// File: rtl/ilb_detector.sv
module ilb_detector
    import ilb_pkg::*;
#(
    parameter int WIN      = 256,
    parameter int MISS_MAX = 16,
    parameter int E1_TICKS = 61440,
    parameter int T1_TICKS = 61760
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       det_en,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  logic       e1_mode,
    input  logic [7:0] act_pat,
    input  logic [1:0] act_len,
    input  logic [7:0] deact_pat,
    input  logic [1:0] deact_len,
    output logic       act_found,
    output logic       deact_found
);
    localparam int NCODE = 2;

    logic [7:0] pat_a  [NCODE];
    logic [1:0] len_a  [NCODE];
    logic       rst_a  [NCODE];
    logic       done_a [NCODE];
    logic       pass_a [NCODE];
    logic       stat_a [NCODE];

    assign pat_a[0] = act_pat;
    assign len_a[0] = act_len;
    assign pat_a[1] = deact_pat;
    assign len_a[1] = deact_len;

    for (genvar g = 0; g < NCODE; g++) begin : g_code
        ilb_matcher #(.WIN(WIN), .MISS_MAX(MISS_MAX)) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (det_en),
            .bit_en  (bit_en),
            .rx_bit  (rx_bit),
            .pat     (pat_a[g]),
            .len_sel (len_a[g]),
            .restart (rst_a[g]),
            .win_done(done_a[g]),
            .win_pass(pass_a[g])
        );
        ilb_persist #(.WIN(WIN), .E1_TICKS(E1_TICKS), .T1_TICKS(T1_TICKS)) u_pers (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (det_en),
            .e1_mode (e1_mode),
            .restart (rst_a[g]),
            .win_done(done_a[g]),
            .win_pass(pass_a[g]),
            .status  (stat_a[g])
        );
    end

    assign act_found   = stat_a[0];
    assign deact_found = stat_a[1];

endmodule

// File: tb/ilb_detector_tb.sv
`timescale 1ns/1ps
module ilb_detector_tb;
    localparam int WIN = 64, MISS_MAX = 8, E1_T = 200, T1_T = 260;

    logic clk = 1'b0, rst_n = 1'b0;
    logic det_en = 1'b0, bit_en = 1'b0, rx_bit = 1'b0, e1_mode = 1'b1;
    logic [7:0] act_pat = 8'h01, deact_pat = 8'h24;
    logic [1:0] act_len = 2'd0, deact_len = 2'd1;
    logic act_found, deact_found;

    int n_tests = 0, n_fail = 0, cycles = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ilb_detector #(.WIN(WIN), .MISS_MAX(MISS_MAX), .E1_TICKS(E1_T), .T1_TICKS(T1_T)) u_dut (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .bit_en(bit_en), .rx_bit(rx_bit),
        .e1_mode(e1_mode), .act_pat(act_pat), .act_len(act_len),
        .deact_pat(deact_pat), .deact_len(deact_len),
        .act_found(act_found), .deact_found(deact_found));

    // Behavioural reference model, one slot per code (0 = activate, 1 = deactivate).
    int hb [2][8];
    int hn [2], mbits [2], mmiss [2], mhit [2], mpend [2], mpass [2], mpers [2], mfound [2];
    logic [7:0] mpat [2];
    logic [1:0] mlen [2];

    function automatic int rot_ok(int c, logic [7:0] p, int len);
        int good;
        for (int r = 0; r < len; r++) begin
            good = 1;
            for (int k = 0; k < len; k++)
                if (hb[c][8 - len + k] != int'(p[(len - 1 - k + r) % len])) good = 0;
            if (good == 1) return 1;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            logic [7:0] p;
            logic [1:0] ls;
            int len, rs, lim;
            p   = (c == 0) ? act_pat : deact_pat;
            ls  = (c == 0) ? act_len : deact_len;
            lim = e1_mode ? E1_T : T1_T;
            if (!rst_n) begin
                hn[c] = 0; mbits[c] = 0; mmiss[c] = 0; mhit[c] = 0; mpend[c] = 0;
                mpass[c] = 0; mpers[c] = 0; mfound[c] = 0; mpat[c] = 8'h00; mlen[c] = 2'd0;
            end else begin
                rs = (!det_en || p != mpat[c] || ls != mlen[c]) ? 1 : 0;
                if (rs == 1) begin
                    mfound[c] = 0; mpers[c] = 0;
                end else if (mpend[c] == 1) begin
                    if (mpass[c] == 0) begin
                        mfound[c] = 0; mpers[c] = 0;
                    end else if (mfound[c] == 0) begin
                        mpers[c] += WIN;
                        if (mpers[c] > lim) begin mfound[c] = 1; mpers[c] = 0; end
                    end
                end
                mpend[c] = 0;
                if (rs == 1) begin
                    hn[c] = 0; mbits[c] = 0; mmiss[c] = 0; mhit[c] = 0;
                    mpat[c] = p; mlen[c] = ls;
                end else if (bit_en) begin
                    len = 5 + int'(mlen[c]);
                    if (hn[c] >= len && hb[c][8 - len] != int'(rx_bit)) mmiss[c]++;
                    for (int k = 0; k < 7; k++) hb[c][k] = hb[c][k + 1];
                    hb[c][7] = int'(rx_bit);
                    if (hn[c] < 8) hn[c]++;
                    if (hn[c] >= len && rot_ok(c, mpat[c], len) == 1) mhit[c] = 1;
                    mbits[c]++;
                    if (mbits[c] == WIN) begin
                        mpend[c] = 1;
                        mpass[c] = (mmiss[c] <= MISS_MAX && mhit[c] == 1) ? 1 : 0;
                        mbits[c] = 0; mmiss[c] = 0; mhit[c] = 0;
                    end
                end
            end
        end
    end

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            n_tests++;
            if (act_found !== (mfound[0] == 1) || deact_found !== (mfound[1] == 1)) begin
                n_fail++;
                $display("FAIL %s model compare: act/deact actual %b%b expected %0d%0d",
                         cur_req, act_found, deact_found, mfound[0], mfound[1]);
            end
        end
    end

    task automatic chk(input logic act, input logic exp_v, input string req);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp_v);
        end
    endtask

    // Send n line bits of an L-bit code, optional periodic errors, framing bits and idle gaps.
    task automatic send(input logic [7:0] p, input int len, input int n,
                        input int err_per, input int frm_per, input int gap);
        int ph = 0;
        logic b;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (frm_per > 0 && (i % frm_per) == frm_per - 1) b = i[0];
            else begin b = p[len - 1 - (ph % len)]; ph++; end
            if (err_per > 0 && (i % err_per) == err_per - 1) b = ~b;
            rx_bit = b;
            bit_en = 1'b1;
            if (gap != 0) begin @(negedge clk); bit_en = 1'b0; end
        end
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(act_found, 1'b0, "R1 act after reset");
        chk(deact_found, 1'b0, "R1 deact after reset");
        rst_n = 1'b1;
        det_en = 1'b1;
        @(negedge clk);
        chk(act_found, 1'b0, "R1 act idle");

        // R2 R5: 5-bit activate code in E1 mode; R3 deactivate stays low
        cur_req = "R5";
        send(8'h01, 5, 400, 0, 0, 0);
        chk(act_found, 1'b1, "R2 R5 5-bit code E1 detected");
        chk(deact_found, 1'b0, "R3 deact untouched by activate code");

        // R9: code removed
        cur_req = "R9";
        send(8'h00, 5, 130, 0, 0, 0);
        chk(act_found, 1'b0, "R9 cleared after failed window");

        // R6 R12 R13: 3-bit code as 6-bit pattern, T1 mode, idle gaps between bits
        cur_req = "R6";
        e1_mode = 1'b0;
        send(8'h24, 6, 300, 0, 0, 1);
        chk(deact_found, 1'b0, "R6 beyond E1 limit but within T1 limit");
        cur_req = "R12";
        send(8'h24, 6, 150, 0, 0, 1);
        chk(deact_found, 1'b1, "R12 R13 deact detected with idle gaps");

        // R7: 8-bit code with one bit error in 97
        cur_req = "R7";
        e1_mode = 1'b1;
        act_pat = 8'hCA; act_len = 2'd3;
        send(8'hCA, 8, 400, 97, 0, 0);
        chk(act_found, 1'b1, "R7 detected under bit errors");
        chk(deact_found, 1'b0, "R9 deact cleared by foreign stream");

        // R8: 7-bit code with framing bits, plus R13 4-bit code as 8-bit pattern config
        cur_req = "R8";
        act_pat = 8'h4B; act_len = 2'd2;
        deact_pat = 8'h88; deact_len = 2'd3;
        send(8'h4B, 7, 500, 0, 193, 0);
        chk(act_found, 1'b1, "R8 detected with framing bits");
        cur_req = "R13";
        send(8'h88, 8, 400, 0, 0, 0);
        chk(deact_found, 1'b1, "R13 4-bit code repeated to 8 bits");

        // R4: right period, wrong pattern
        cur_req = "R4";
        act_pat = 8'h01; act_len = 2'd0;
        send(8'h03, 5, 300, 0, 0, 0);
        chk(act_found, 1'b0, "R4 wrong pattern rejected");

        // R10: pattern rewritten while detected
        cur_req = "R10";
        send(8'h01, 5, 400, 0, 0, 0);
        chk(act_found, 1'b1, "R10 detected before change");
        act_pat = 8'h02;
        @(negedge clk);
        chk(act_found, 1'b0, "R10 dropped after pattern change");
        send(8'h01, 5, 400, 0, 0, 0);
        chk(act_found, 1'b1, "R2 rotation re-detected");

        // R11: disable
        cur_req = "R11";
        det_en = 1'b0;
        @(negedge clk);
        chk(act_found, 1'b0, "R11 dropped on disable");
        send(8'h02, 5, 300, 0, 0, 0);
        chk(act_found, 1'b0, "R11 nothing accumulates while disabled");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cycles >= 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule